// File: doc/BRIEF.md
# Predicated Lane-Partitioned Vector Adder

This block adds two wide vectors lane by lane, with the lane width picked at run time. The vector is split into independent elements of 8, 16, 32, 64 or 128 bits. No carry crosses from one element into its neighbour, so each element's sum wraps on its own. A predicate vector with one bit per data byte decides which elements are written. For elements wider than one byte, only the lowest predicate bit of the element's byte group counts.

An element that is not written is handled by a mode input. In zeroing mode it is cleared. In merging mode it takes the value of the first source operand, which plays the role of the destination's previous contents. A length setting, counted in 128-bit granules, can shorten the active vector below the hardware width. Granules beyond the effective length are always written as zero.

Operands enter through a valid/ready handshake and the result leaves through another. There is one registered stage. The input side is ready whenever the output register is empty or is being drained in the same cycle. While the output is valid and not taken, the output holds still and the input side stalls. The hardware width `VW` is a parameter and must be a multiple of 128 bits, between 128 and 2048.

Top module: `lane_split_adder`

## Requirements
- R1: `elem_sz` selects the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64, 4 = 128 bits. Codes 5 to 7 behave as 8-bit. Each active element's result is (a + b) modulo 2^width.
- R2: A carry out of the top bit of an element never reaches the next element. Element k covers bits [k*W +: W], where W is the element width.
- R3: Element k is active when predicate bit k*W/8 is 1, that is, the lowest bit of its byte group. The other predicate bits of the group have no effect.
- R4: With `merge_en` = 0, an inactive element inside the effective length is written as zero.
- R5: With `merge_en` = 1, an inactive element inside the effective length is written with the matching bits of `src_a`.
- R6: The effective length is (`len_sel` + 1) * 128 bits, clamped to `VW`. Granules at or above it are written as zero whatever the predicate and mode.
- R7: When `in_valid` and `in_ready` are both high at a rising edge, `out_valid` is high and `out_data` holds that input's result after that edge. `in_ready` equals (not `out_valid`) or `out_ready`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: Synchronous reset clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Operand set can be taken this cycle |
| src_a | input | VW | First source; merge value for inactive elements |
| src_b | input | VW | Second source |
| pred | input | VW/8 | One predicate bit per data byte |
| elem_sz | input | 3 | Element width code |
| merge_en | input | 1 | 1 = merging, 0 = zeroing of inactive elements |
| len_sel | input | 4 | Effective length in 128-bit granules, minus one |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VW | Registered result vector |

## Verification
The assertions check the handshake on every cycle. An accepted input must show up as a valid output one edge later. A stalled output must hold its data. A drained register with no new input must go empty. Every granule past the effective length of an accepted input must come out as zero. The lane arithmetic needs the bench's directed scenarios with known operands and predicates to show it is right. That covers carries stopped at element edges for each width, the lowest-bit-of-group rule, zeroing versus merging, the fallback for unused size codes, and length clamping.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int GRAN_BITS = 128;
  localparam int MAX_VW    = 2048;
  localparam int LEN_W     = 4;

  typedef enum logic [2:0] {
    ESZ_B8   = 3'd0,
    ESZ_B16  = 3'd1,
    ESZ_B32  = 3'd2,
    ESZ_B64  = 3'd3,
    ESZ_B128 = 3'd4
  } esz_e;

  // log2 of element width in bytes; unused codes fall back to bytes
  function automatic logic [2:0] esz_log2(input logic [2:0] code);
    case (code)
      ESZ_B16:  return 3'd1;
      ESZ_B32:  return 3'd2;
      ESZ_B64:  return 3'd3;
      ESZ_B128: return 3'd4;
      default:  return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/lsa_lane_mask.sv
module lsa_lane_mask #(
  parameter int VW = 256,
  localparam int NB = VW / 8,
  localparam int NG = VW / 128
) (
  input  logic [NB-1:0]        pred,
  input  logic [2:0]           sz_log2,
  input  logic [$clog2(NG+1)-1:0] eff_gran,
  output logic [NB-1:0]        byte_act,
  output logic [NB-1:0]        byte_inlen,
  output logic [NB-1:0]        carry_cut
);
  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int B1 = b & ~1;
    localparam int B2 = b & ~3;
    localparam int B3 = b & ~7;
    localparam int B4 = b & ~15;
    localparam int GR = b / 16;
    logic gov;

    always_comb begin
      case (sz_log2)
        3'd1: begin gov = pred[B1]; carry_cut[b] = (b % 2) == 0;  end
        3'd2: begin gov = pred[B2]; carry_cut[b] = (b % 4) == 0;  end
        3'd3: begin gov = pred[B3]; carry_cut[b] = (b % 8) == 0;  end
        3'd4: begin gov = pred[B4]; carry_cut[b] = (b % 16) == 0; end
        default: begin gov = pred[b]; carry_cut[b] = 1'b1; end
      endcase
    end

    assign byte_inlen[b] = eff_gran > ($clog2(NG+1))'(GR);
    assign byte_act[b]   = gov & byte_inlen[b];
  end
endmodule

// File: rtl/lsa_seg_adder.sv
module lsa_seg_adder #(
  parameter int VW = 256,
  localparam int NB = VW / 8
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic [NB-1:0] cut,
  output logic [VW-1:0] sum
);
  logic [NB:0] cy;
  assign cy[0] = 1'b0;

  for (genvar i = 0; i < NB; i++) begin : g_slice
    logic cin;
    logic [8:0] part;
    assign cin  = cut[i] ? 1'b0 : cy[i];
    assign part = {1'b0, a[i*8 +: 8]} + {1'b0, b[i*8 +: 8]} + {8'd0, cin};
    assign sum[i*8 +: 8] = part[7:0];
    assign cy[i+1] = part[8];
  end
endmodule

// File: rtl/lsa_merge.sv
module lsa_merge #(
  parameter int VW = 256,
  localparam int NB = VW / 8
) (
  input  logic [VW-1:0] sum,
  input  logic [VW-1:0] keep,
  input  logic [NB-1:0] act,
  input  logic [NB-1:0] inlen,
  input  logic          merge_en,
  output logic [VW-1:0] res
);
  for (genvar i = 0; i < NB; i++) begin : g_sel
    always_comb begin
      if (act[i])                  res[i*8 +: 8] = sum[i*8 +: 8];
      else if (inlen[i] && merge_en) res[i*8 +: 8] = keep[i*8 +: 8];
      else                         res[i*8 +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/lane_split_adder.sv
module lane_split_adder
  import lsa_pkg::*;
#(
  parameter int VW = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [VW-1:0]         src_a,
  input  logic [VW-1:0]         src_b,
  input  logic [VW/8-1:0]       pred,
  input  logic [2:0]            elem_sz,
  input  logic                  merge_en,
  input  logic [LEN_W-1:0]      len_sel,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [VW-1:0]         out_data
);
  localparam int NB  = VW / 8;
  localparam int NG  = VW / GRAN_BITS;
  localparam int GW  = $clog2(NG + 1);

  logic [GW-1:0]    eff_gran;
  logic [LEN_W:0]   req_gran;
  logic [NB-1:0]    byte_act, byte_inlen, carry_cut;
  logic [VW-1:0]    raw_sum, next_res;
  logic             take;

  // requested granules, clamped to what the hardware holds
  assign req_gran = {1'b0, len_sel} + (LEN_W+1)'(1);
  assign eff_gran = (req_gran >= (LEN_W+1)'(NG)) ? GW'(NG) : GW'(req_gran);

  lsa_lane_mask #(.VW(VW)) u_mask (
    .pred       (pred),
    .sz_log2    (esz_log2(elem_sz)),
    .eff_gran   (eff_gran),
    .byte_act   (byte_act),
    .byte_inlen (byte_inlen),
    .carry_cut  (carry_cut)
  );

  lsa_seg_adder #(.VW(VW)) u_add (
    .a   (src_a),
    .b   (src_b),
    .cut (carry_cut),
    .sum (raw_sum)
  );

  lsa_merge #(.VW(VW)) u_sel (
    .sum      (raw_sum),
    .keep     (src_a),
    .act      (byte_act),
    .inlen    (byte_inlen),
    .merge_en (merge_en),
    .res      (next_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7: accepted operands appear as a valid result one edge later
  p_accept_to_valid_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  // R8: a stalled result is held
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7: draining with nothing new empties the register
  p_drain_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R6: granules past the effective length come out zero
  for (genvar g = 0; g < NG; g++) begin : g_lenchk
    p_beyond_len_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (take && (eff_gran <= GW'(g))) |=> (out_data[g*GRAN_BITS +: GRAN_BITS] == '0));
  end
endmodule

// File: tb/sim_lane_split_adder.sv
module sim_lane_split_adder;
  localparam int VW = 256;
  localparam int NB = VW / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1, merge_en = 1'b0;
  logic [VW-1:0] src_a = '0, src_b = '0, out_data;
  logic [NB-1:0] pred = '0;
  logic [2:0] elem_sz = 3'd0;
  logic [3:0] len_sel = 4'd15;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lane_split_adder #(.VW(VW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .src_a(src_a), .src_b(src_b), .pred(pred), .elem_sz(elem_sz),
    .merge_en(merge_en), .len_sel(len_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  function automatic logic [VW-1:0] pat(input int seed);
    logic [VW-1:0] v;
    for (int i = 0; i < NB; i++) v[i*8 +: 8] = 8'((i * 37 + seed * 11 + 5) & 255);
    return v;
  endfunction

  // independent element-wise reference
  function automatic logic [VW-1:0] model(input logic [VW-1:0] a, input logic [VW-1:0] b,
      input logic [NB-1:0] p, input logic [2:0] sz, input logic mg, input logic [3:0] ln);
    int eb, effb;
    logic [VW-1:0] r;
    logic [127:0] m, xa, xb;
    case (sz)
      3'd1: eb = 2; 3'd2: eb = 4; 3'd3: eb = 8; 3'd4: eb = 16; default: eb = 1;
    endcase
    effb = (int'(ln) + 1) * 16;
    if (effb > NB) effb = NB;
    m = (eb == 16) ? {128{1'b1}} : ((128'd1 << (eb * 8)) - 128'd1);
    r = '0;
    for (int base = 0; base < NB; base += eb) begin
      xa = 128'(a >> (base * 8)) & m;
      xb = 128'(b >> (base * 8)) & m;
      if (base < effb) begin
        if (p[base]) r = r | (VW'((xa + xb) & m) << (base * 8));
        else if (mg) r = r | (VW'(xa) << (base * 8));
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic v_exp, input logic [VW-1:0] d_exp);
    n_chk++;
    if (out_valid !== v_exp || out_data !== d_exp) begin
      n_bad++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               req, out_valid, out_data, v_exp, d_exp);
    end
  endtask

  task automatic run(input string req, input logic [VW-1:0] a, input logic [VW-1:0] b,
      input logic [NB-1:0] p, input logic [2:0] sz, input logic mg, input logic [3:0] ln);
    @(negedge clk);
    src_a = a; src_b = b; pred = p; elem_sz = sz; merge_en = mg; len_sel = ln;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, 1'b1, model(a, b, p, sz, mg, ln));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R9 reset", 1'b0, '0);
    n_chk++;
    if (in_ready !== 1'b1) begin
      n_bad++; $display("FAIL R7 in_ready after reset: %0b expected 1", in_ready);
    end
  endtask

  task automatic t_sizes();  // R1 each element width, full predicate
    for (int s = 0; s < 5; s++) run("R1 size sweep", pat(s), pat(s + 9), '1, 3'(s), 1'b0, 4'd15);
    run("R1 unused code 6 as bytes", pat(3), pat(4), '1, 3'd6, 1'b0, 4'd15);
    run("R1 unused code 7 as bytes", '1, {NB{8'h01}}, '1, 3'd7, 1'b0, 4'd15);
  endtask

  task automatic t_carry();  // R2 all-ones plus one wraps each element alone
    for (int s = 0; s < 5; s++) run("R2 carry stop", '1, {NB{8'h01}}, '1, 3'(s), 1'b0, 4'd15);
  endtask

  task automatic t_pred_group();  // R3 only lowest bit of each group
    run("R3 upper group bits ignored", pat(1), pat(2), {NB/4{4'b1110}}, 3'd2, 1'b0, 4'd15);
    run("R3 lowest bit alone enables", pat(1), pat(2), {NB/4{4'b0001}}, 3'd2, 1'b0, 4'd15);
    run("R3 mixed 64-bit groups", pat(5), pat(6), 32'h0100_FE01, 3'd3, 1'b1, 4'd15);
  endtask

  task automatic t_modes();  // R4 zeroing, R5 merging
    run("R4 zeroing inactive", pat(7), pat(8), 32'h5555_00FF, 3'd0, 1'b0, 4'd15);
    run("R5 merging inactive", pat(7), pat(8), 32'h5555_00FF, 3'd0, 1'b1, 4'd15);
    run("R5 merging 16-bit", pat(2), pat(3), 32'h0F0F_3333, 3'd1, 1'b1, 4'd15);
  endtask

  task automatic t_length();  // R6 shortened and clamped length
    run("R6 one granule merge", pat(1), pat(2), 32'h00FF_FFFF, 3'd0, 1'b1, 4'd0);
    run("R6 one granule zero", pat(3), pat(4), '1, 3'd4, 1'b0, 4'd0);
    run("R6 clamp at width", pat(5), pat(6), '1, 3'd2, 1'b1, 4'd7);
  endtask

  task automatic t_stall();  // R7/R8 back-pressure
    logic [VW-1:0] e1, e2;
    e1 = model(pat(10), pat(11), '1, 3'd2, 1'b0, 4'd15);
    e2 = model(pat(12), pat(13), '1, 3'd0, 1'b0, 4'd15);
    @(negedge clk);
    out_ready = 1'b0;
    src_a = pat(10); src_b = pat(11); pred = '1; elem_sz = 3'd2; merge_en = 1'b0; len_sel = 4'd15;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7 first result", 1'b1, e1);
    src_a = pat(12); src_b = pat(13); elem_sz = 3'd0;
    n_chk++;
    if (in_ready !== 1'b0) begin
      n_bad++; $display("FAIL R7 in_ready during stall: %0b expected 0", in_ready);
    end
    @(posedge clk);
    @(negedge clk);
    check("R8 held under stall", 1'b1, e1);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 drain and refill", 1'b1, e2);
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R7 empty after drain: %0b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_sizes();
    t_carry();
    t_pred_group();
    t_modes();
    t_length();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule